// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low external interrupt pin and turns it into a latched interrupt request for a processor core. The pin is asynchronous to the core clock, so it first passes through a flop synchronizer. A falling edge of the synchronized level sets an interrupt latch. An optional mode also keeps the request alive while the pin stays low. The synchronized level is also brought out so that branch-on-pin instructions can test it.

Software uses a single-cycle control port. A write sets the trigger mode and the mask, and can acknowledge the request in the same write. A read returns the mode, the mask and the raw latch state. A vector-fetch strobe from the core clears the latch in the same way as a software acknowledge. The global interrupt mask of the core, the arbitration between sources, the pull-up and any high-voltage detection are handled outside this block.

Top module: `ext_irq_ctrl`

## Requirements
- R1: `pin_level_o` equals the value `pin_i` had two rising clock edges earlier, and it reads 1 while reset is held.
- R2: A synchronized 1-to-0 transition sets the latch (`rd_flag_o`) on the next clock edge in either mode. No other condition sets the latch.
- R3: With `rd_mode_o`=0 (edge only), a clear event clears the latch on the next edge whatever the pin level. A clear event is `vec_fetch_i`=1, or `wr_en_i`=1 together with `wr_ack_i`=1.
- R4: With `rd_mode_o`=1 (edge and level), the latch clears only once a clear event has occurred and `pin_level_o` is 1. The two may happen in either order, and the latch stays set for as long as the synchronized pin stays low.
- R5: When a falling edge and a clear event arrive in the same cycle, the latch is set, so the event is not lost.
- R6: `irq_o` is 1 exactly when the latch is set and `rd_mask_o` is 0. Masking never changes `rd_flag_o`.
- R7: A write with `wr_en_i`=1 loads `rd_mode_o` from `wr_mode_i` and `rd_mask_o` from `wr_mask_i` on the next edge. The acknowledge bit is never stored or read back.
- R8: Reset clears the latch, the mode and the mask, so the request is removed even while the pin is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous external interrupt pin, active low |
| vec_fetch_i | input | 1 | Vector-fetch strobe from the core; acts as a clear event |
| wr_en_i | input | 1 | Control register write enable |
| wr_mode_i | input | 1 | Write data: 1 selects edge-and-level triggering |
| wr_mask_i | input | 1 | Write data: 1 masks the request output |
| wr_ack_i | input | 1 | Write data: 1 acknowledges (clears) the request |
| rd_mode_o | output | 1 | Read data: current trigger mode |
| rd_mask_o | output | 1 | Read data: current mask |
| rd_flag_o | output | 1 | Read data: latch state, not affected by the mask |
| irq_o | output | 1 | Interrupt request to the core |
| pin_level_o | output | 1 | Synchronized pin level for pin-test branches |

## Verification
The assertions assume that reset is applied for at least one clock edge and that `pin_i` is high while reset is held. Without that, the synchronizer could report a stale level in the first cycles after reset. The clear-event and set-priority properties use only the synchronized level, so they also hold when the pin changes at random. The stimulus changes `pin_i` and the write port only on falling clock edges. It keeps the pin high during every reset, and it mixes directed ordering cases with a random stretch of pin toggles and clear strobes.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic mode;  // 1: edge and level
    logic mask;
  } irq_ctrl_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  localparam int unsigned LAST = STAGES - 1;
  logic [LAST:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b1;
    else         stage_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b1;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign sync_o = stage_q[LAST];
endmodule

// File: rtl/ext_irq_fall.sv
module ext_irq_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= level_i;
  end

  assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  logic      wr_mode_i,
  input  logic      wr_mask_i,
  output irq_ctrl_t ctrl_o
);
  irq_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q.mode <= wr_mode_i;
      ctrl_q.mask <= wr_mask_i;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic clr_i,
  input  logic level_mode_i,
  input  logic pin_high_i,
  output logic latch_o
);
  logic latch_q, latch_d;
  logic acked_q, acked_d;  // clear seen, waiting for pin release
  logic ack_now;

  assign ack_now = clr_i | acked_q;

  always_comb begin
    latch_d = latch_q;
    acked_d = acked_q;
    if (fall_i) begin
      latch_d = 1'b1;  // set wins over clear
      acked_d = 1'b0;
    end else if (!latch_q) begin
      acked_d = 1'b0;
    end else if (level_mode_i) begin
      if (ack_now && pin_high_i) begin
        latch_d = 1'b0;
        acked_d = 1'b0;
      end else begin
        acked_d = ack_now;
      end
    end else if (clr_i) begin
      latch_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      acked_q <= 1'b0;
    end else begin
      latch_q <= latch_d;
      acked_q <= acked_d;
    end
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic vec_fetch_i,
  input  logic wr_en_i,
  input  logic wr_mode_i,
  input  logic wr_mask_i,
  input  logic wr_ack_i,
  output logic rd_mode_o,
  output logic rd_mask_o,
  output logic rd_flag_o,
  output logic irq_o,
  output logic pin_level_o
);
  logic      pin_sync, fall, clr, latch;
  irq_ctrl_t ctrl;

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(pin_i), .sync_o(pin_sync)
  );

  ext_irq_fall u_fall (
    .clk_i, .rst_ni, .level_i(pin_sync), .fall_o(fall)
  );

  ext_irq_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_mode_i, .wr_mask_i, .ctrl_o(ctrl)
  );

  assign clr = vec_fetch_i | (wr_en_i & wr_ack_i);

  ext_irq_latch u_latch (
    .clk_i, .rst_ni, .fall_i(fall), .clr_i(clr),
    .level_mode_i(ctrl.mode), .pin_high_i(pin_sync), .latch_o(latch)
  );

  assign rd_mode_o   = ctrl.mode;
  assign rd_mask_o   = ctrl.mask;
  assign rd_flag_o   = latch;
  assign irq_o       = latch & ~ctrl.mask;
  assign pin_level_o = pin_sync;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_i,
  input logic vec_fetch_i,
  input logic wr_en_i,
  input logic wr_mode_i,
  input logic wr_mask_i,
  input logic wr_ack_i,
  input logic rd_mode_o,
  input logic rd_mask_o,
  input logic rd_flag_o,
  input logic irq_o,
  input logic pin_level_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEARS: assert (!rd_flag_o && !rd_mode_o && !rd_mask_o && !irq_o); // R8
  end

  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_level_o) |=> rd_flag_o); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_flag_o && !$fell(pin_level_o)) |=> !rd_flag_o); // R2

  AST_EDGE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_flag_o && !rd_mode_o && (vec_fetch_i || (wr_en_i && wr_ack_i)) && !$fell(pin_level_o))
    |=> !rd_flag_o); // R3

  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_flag_o && rd_mode_o && !pin_level_o) |=> rd_flag_o); // R4

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pin_level_o) && (vec_fetch_i || (wr_en_i && wr_ack_i))) |=> rd_flag_o); // R5

  AST_MASK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rd_flag_o && !rd_mask_o)); // R6

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_mode_o == $past(wr_mode_i) && rd_mask_o == $past(wr_mask_i))); // R7

  AST_CTRL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(rd_mode_o) && $stable(rd_mask_o))); // R7
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk chk_i (.*);

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1, vf = 1'b0, we = 1'b0, wmode = 1'b0, wmask = 1'b0, wack = 1'b0;
  logic rd_mode, rd_mask, rd_flag, irq, pin_lvl;

  int checks = 0;
  int errors = 0;
  string phase = "R8";
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .vec_fetch_i(vf),
    .wr_en_i(we), .wr_mode_i(wmode), .wr_mask_i(wmask), .wr_ack_i(wack),
    .rd_mode_o(rd_mode), .rd_mask_o(rd_mask), .rd_flag_o(rd_flag),
    .irq_o(irq), .pin_level_o(pin_lvl)
  );

  // reference model
  bit m_delay[$] = '{1'b1};
  bit m_sync = 1, m_prev = 1, m_lat = 0, m_ackd = 0, m_mode = 0, m_mask = 0;

  always @(posedge clk) begin
    bit clr, fall;
    if (!rst_n) begin
      m_delay = '{1'b1}; m_sync = 1; m_prev = 1;
      m_lat = 0; m_ackd = 0; m_mode = 0; m_mask = 0;
    end else begin
      clr  = vf || (we && wack);
      fall = m_prev && !m_sync;
      if (fall) begin
        m_lat = 1; m_ackd = 0;
      end else if (!m_lat) begin
        m_ackd = 0;
      end else if (m_mode) begin
        if (clr) m_ackd = 1;
        if (m_ackd && m_sync) begin m_lat = 0; m_ackd = 0; end
      end else if (clr) begin
        m_lat = 0;
      end
      m_prev = m_sync;
      m_sync = m_delay.pop_front();
      m_delay.push_back(pin);
      if (we) begin m_mode = wmode; m_mask = wmask; end
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1", "pin_level_o", pin_lvl, m_sync);
      check(phase, "rd_flag_o", rd_flag, m_lat);
      check("R6", "irq_o", irq, m_lat && !m_mask);
      check("R7", "rd_mode_o", rd_mode, m_mode);
      check("R7", "rd_mask_o", rd_mask, m_mask);
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      vf = 0; we = 0; wack = 0;
    end
  endtask

  task automatic set_pin(logic v, int wait_n);
    @(negedge clk); pin = v; vf = 0; we = 0; wack = 0;
    idle(wait_n);
  endtask

  task automatic fetch();
    @(negedge clk); vf = 1; we = 0;
    @(negedge clk); vf = 0;
  endtask

  task automatic wr(logic md, logic mk, logic ak);
    @(negedge clk); we = 1; wmode = md; wmask = mk; wack = ak; vf = 0;
    @(negedge clk); we = 0; wack = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    check("R8", "reset flag", rd_flag, 1'b0);
    check("R8", "reset mode", rd_mode, 1'b0);
    check("R1", "reset pin level", pin_lvl, 1'b1);

    // R2/R3 edge mode: fetch clears while pin still low
    phase = "R2";
    set_pin(0, 4);
    check("R2", "flag after edge", rd_flag, 1'b1);
    phase = "R3";
    fetch(); idle(1);
    check("R3", "flag after fetch (pin low)", rd_flag, 1'b0);
    set_pin(1, 4);
    set_pin(0, 4);
    wr(0, 0, 1); idle(1);
    check("R3", "flag after ack write", rd_flag, 1'b0);
    set_pin(1, 4);

    // R4 level mode, ack before release
    wr(1, 0, 0);
    phase = "R4";
    set_pin(0, 4);
    wr(1, 0, 1); idle(3);
    check("R4", "held while pin low after ack", rd_flag, 1'b1);
    set_pin(1, 4);
    check("R4", "cleared after release", rd_flag, 1'b0);
    // release before fetch
    set_pin(0, 4);
    set_pin(1, 5);
    check("R4", "still set after release without clear", rd_flag, 1'b1);
    fetch(); idle(1);
    check("R4", "cleared after fetch", rd_flag, 1'b0);

    // R5 set vs clear collisions, both modes
    phase = "R5";
    for (int md = 0; md < 2; md++) begin
      wr(md[0], 0, 0);
      for (int off = 0; off < 5; off++) begin
        set_pin(0, 4);
        set_pin(1, 3);
        @(negedge clk); pin = 0;
        repeat (off) @(negedge clk);
        vf = 1;
        @(negedge clk); vf = 0;
        idle(4);
        set_pin(1, 3);
        fetch(); idle(2);
      end
    end

    // R6 mask
    phase = "R6";
    wr(0, 1, 0);
    set_pin(0, 4);
    check("R6", "irq masked", irq, 1'b0);
    check("R6", "flag kept under mask", rd_flag, 1'b1);
    wr(0, 0, 0); idle(1);
    check("R6", "irq after unmask", irq, 1'b1);
    set_pin(1, 3);
    fetch(); idle(1);

    // R8 reset with pin low in level mode
    phase = "R8";
    wr(1, 1, 0);
    set_pin(0, 4);
    @(negedge clk); pin = 1; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); pin = 0;
    @(negedge clk);
    check("R8", "flag after reset", rd_flag, 1'b0);
    check("R8", "mode after reset", rd_mode, 1'b0);
    set_pin(1, 4);

    // random mix
    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      pin = ($urandom % 4) != 0 ? pin : ~pin;
      vf = ($urandom % 8) == 0;
      we = ($urandom % 16) == 0;
      wmode = $urandom; wmask = $urandom; wack = $urandom;
    end
    idle(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule